// File: doc/BRIEF.md
# Segment Checkout/Checkin Order Sequencer

This block places the checkout and checkin operations issued against each memory segment into one total order per segment. It hands every new operation a ticket taken from that segment's issue counter. The engine that walks the cache (invalidate for a checkout, flush for a checkin) asks whether its ticket is being served before it may finish. When it has finished, it reports completion, and the serving counter of that segment advances. Completion is therefore strictly in ticket order within a segment, while segments run independently of one another.

The block also detects a checkin that precedes a checkout on the same segment. When a checkout is issued while an earlier checkin on that segment is still outstanding, the block flags the pairing at issue time and raises a per-segment load-hold line toward the core. The core keeps loads to that segment waiting until every checkin issued before that checkout has completed.

Top module: `ckio_order_seq`

## Requirements
- R1: After reset every segment's issue and serving counters are zero, so the first ticket handed out on any segment is 0 and ticket 0 is granted; all load-hold lines are low.
- R2: When `iss_vld` is high, `iss_tkt` shows in the same cycle the ticket given to that operation. Successive issues on one segment receive consecutive tickets, and issues on other segments do not affect it.
- R3: `ask_grant` is high exactly when `ask_tkt` equals the number of completions on segment `ask_seg` since reset, modulo 2^TW.
- R4: A completion (`fin_vld`) advances only the serving count of `fin_seg`.
- R5: Operation kind encoding on `iss_ckin` and `fin_ckin`: 1 is a checkin, 0 is a checkout.
- R6: A checkout issued while a checkin issued earlier on the same segment has not completed drives `iss_paired` high in that cycle, and `ld_hold` for that segment is high from the next cycle.
- R7: `ld_hold` of a segment falls in the cycle after the completion of the last checkin that was issued before the most recent paired checkout. Checkins issued after that checkout do not hold it up.
- R8: A checkout issued with no outstanding earlier checkin on its segment leaves `iss_paired` low, and `ld_hold` does not rise. This includes the case where that segment's last outstanding checkin completes in the same cycle.
- R9: Tickets and serving counts wrap modulo 2^TW, and grant remains correct across the wrap while fewer than 2^TW operations are outstanding per segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Issue a new operation (take a ticket) |
| iss_seg | input | SW | Segment of the issued operation |
| iss_ckin | input | 1 | Kind of the issued operation: 1 checkin, 0 checkout |
| iss_tkt | output | TW | Ticket assigned to the issued operation |
| iss_paired | output | 1 | Issued checkout follows an outstanding checkin on its segment |
| ask_seg | input | SW | Segment for the grant query |
| ask_tkt | input | TW | Ticket for the grant query |
| ask_grant | output | 1 | Queried ticket is being served on that segment |
| fin_vld | input | 1 | The operation being served has completed |
| fin_seg | input | SW | Segment of the completing operation |
| fin_ckin | input | 1 | Kind of the completing operation: 1 checkin, 0 checkout |
| ld_hold | output | NSEG | Per-segment request to hold loads |

## Verification
The hardest situations to reach are the edges of the hold window. The first is a checkout issued in the very cycle in which its segment's last outstanding checkin completes. The second is a window in which checkins issued after the paired checkout are still pending when the fence clears. Both need an issue and a completion landing on one segment in the same cycle, with a particular mix of kinds queued ahead. Directed sequences set up exactly these cases first. A long pseudo-random sweep over four segments with a 4-bit ticket follows, with issue, completion and query on every cycle. It keeps a model of sequence numbers and operation kinds per segment, wraps tickets many times, and compares every ticket, grant, pairing flag and hold line against it.

// File: rtl/ckio_seq_pkg.sv
package ckio_seq_pkg;
  typedef enum logic {
    OP_CHECKOUT = 1'b0,
    OP_CHECKIN  = 1'b1
  } op_kind_e;
endpackage

// File: rtl/ckio_seg_lane.sv
module ckio_seg_lane
  import ckio_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_hit,
  input  op_kind_e      iss_kind,
  input  logic          fin_hit,
  input  op_kind_e      fin_kind,
  output logic [TW-1:0] next_tkt,
  output logic [TW-1:0] serve_tkt,
  output logic          paired,
  output logic          hold
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] next_q, next_d;
  logic [TW-1:0] serve_q, serve_d;
  logic [TW-1:0] pend_q, pend_d;      // checkins outstanding
  logic [TW-1:0] last_ci_q, last_ci_d; // ticket of newest checkin
  logic [TW-1:0] fence_q, fence_d;    // serve value that ends the hold
  logic          hold_q, hold_d;
  logic [TW-1:0] pend_left;
  logic          iss_co, iss_ci, fin_ci;

  always_comb begin
    iss_ci    = iss_hit && (iss_kind == OP_CHECKIN);
    iss_co    = iss_hit && (iss_kind == OP_CHECKOUT);
    fin_ci    = fin_hit && (fin_kind == OP_CHECKIN);
    pend_left = pend_q - (fin_ci ? ONE : '0);
    paired    = iss_co && (pend_left != '0);

    next_d    = iss_hit ? next_q + ONE : next_q;
    serve_d   = fin_hit ? serve_q + ONE : serve_q;
    pend_d    = pend_left + (iss_ci ? ONE : '0);
    last_ci_d = iss_ci ? next_q : last_ci_q;
    fence_d   = paired ? last_ci_q + ONE : fence_q;

    if (paired)
      hold_d = 1'b1;
    else if (hold_q && fin_hit && (serve_q + ONE == fence_q))
      hold_d = 1'b0;
    else
      hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q    <= '0;
      serve_q   <= '0;
      pend_q    <= '0;
      last_ci_q <= '0;
      fence_q   <= '0;
      hold_q    <= 1'b0;
    end else begin
      if (iss_hit)          next_q    <= next_d;
      if (fin_hit)          serve_q   <= serve_d;
      if (iss_ci || fin_ci) pend_q    <= pend_d;
      if (iss_ci)           last_ci_q <= last_ci_d;
      if (paired)           fence_q   <= fence_d;
      hold_q <= hold_d;
    end
  end

  assign next_tkt  = next_q;
  assign serve_tkt = serve_q;
  assign hold      = hold_q;

  // R4: a completion needs an outstanding operation
  a_r4_fin_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fin_hit |-> (next_q != serve_q));

  // R9: issue must not overrun the serving pointer
  a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_hit && !fin_hit) |-> ((next_q + ONE) != serve_q));

  // R4: serving count moves only on a completion
  a_r4_serve_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_hit |=> $stable(serve_q));

  // R6: a paired checkout raises the hold next cycle
  a_r6_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
    paired |=> hold_q);

  // R7: hold only while some checkin is outstanding
  a_r7_hold_has_ckin: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (pend_q != '0));
endmodule

// File: rtl/ckio_order_seq.sv
module ckio_order_seq
  import ckio_seq_pkg::*;
#(
  parameter int NSEG = 4,
  parameter int TW   = 4,
  parameter int SW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_vld,
  input  logic [SW-1:0]   iss_seg,
  input  logic            iss_ckin,
  output logic [TW-1:0]   iss_tkt,
  output logic            iss_paired,
  input  logic [SW-1:0]   ask_seg,
  input  logic [TW-1:0]   ask_tkt,
  output logic            ask_grant,
  input  logic            fin_vld,
  input  logic [SW-1:0]   fin_seg,
  input  logic            fin_ckin,
  output logic [NSEG-1:0] ld_hold
);
  logic [TW-1:0]   next_a  [NSEG];
  logic [TW-1:0]   serve_a [NSEG];
  logic [NSEG-1:0] pair_v;
  op_kind_e        iss_kind, fin_kind;

  assign iss_kind = op_kind_e'(iss_ckin);
  assign fin_kind = op_kind_e'(fin_ckin);

  for (genvar g = 0; g < NSEG; g++) begin : g_lane
    ckio_seg_lane #(.TW(TW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_hit   (iss_vld && (iss_seg == SW'(g))),
      .iss_kind  (iss_kind),
      .fin_hit   (fin_vld && (fin_seg == SW'(g))),
      .fin_kind  (fin_kind),
      .next_tkt  (next_a[g]),
      .serve_tkt (serve_a[g]),
      .paired    (pair_v[g]),
      .hold      (ld_hold[g])
    );
  end

  always_comb begin
    iss_tkt   = '0;
    ask_grant = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (iss_seg == SW'(i)) iss_tkt   = next_a[i];
      if (ask_seg == SW'(i)) ask_grant = (serve_a[i] == ask_tkt);
    end
    iss_paired = |pair_v;
  end

  // R6: pairing is only ever reported for a checkout issue
  a_r6_pair_is_checkout: assert property (@(posedge clk) disable iff (!rst_n)
    iss_paired |-> (iss_vld && !iss_ckin));

  // R6: at most one lane pairs per cycle
  a_r6_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_v));
endmodule

// File: tb/tb_ckio_order_seq.sv
`timescale 1ns/1ps
module tb_ckio_order_seq;
  localparam int NSEG = 4;
  localparam int TW   = 4;
  localparam int SW   = 2;
  localparam int MODV = 1 << TW;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_vld, iss_ckin, fin_vld, fin_ckin, iss_paired, ask_grant;
  logic [SW-1:0] iss_seg, ask_seg, fin_seg;
  logic [TW-1:0] iss_tkt, ask_tkt;
  logic [NSEG-1:0] ld_hold;

  always #10 clk = ~clk;

  ckio_order_seq #(.NSEG(NSEG), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_seg(iss_seg), .iss_ckin(iss_ckin),
    .iss_tkt(iss_tkt), .iss_paired(iss_paired),
    .ask_seg(ask_seg), .ask_tkt(ask_tkt), .ask_grant(ask_grant),
    .fin_vld(fin_vld), .fin_seg(fin_seg), .fin_ckin(fin_ckin),
    .ld_hold(ld_hold)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // model: sequence numbers per segment, kinds by sequence
  int acq_n [NSEG];
  int fin_n [NSEG];
  int last_co [NSEG];
  bit kind_m [NSEG][64];
  logic [31:0] lf = 32'h1bad_5eed;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd(input int m);
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return int'(lf % 32'(m));
  endfunction

  function automatic bit hold_exp(input int s);
    if (last_co[s] < 0) return 1'b0;
    for (int q = fin_n[s]; q < last_co[s]; q++)
      if (kind_m[s][q % 64]) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: issue, completion and grant query
  task automatic step(input bit av, input int as, input bit ak,
                      input bit dv, input int ds, input int qs, input int qt);
    int fin_after;
    bit pair_e;
    @(negedge clk);
    iss_vld = av; iss_seg = SW'(as); iss_ckin = ak;
    fin_vld = dv; fin_seg = SW'(ds);
    fin_ckin = dv ? kind_m[ds][fin_n[ds] % 64] : 1'b0;
    ask_seg = SW'(qs); ask_tkt = TW'(qt);
    #1;
    // R3 grant against completions so far
    chk("R3 grant", int'(ask_grant), int'((fin_n[qs] % MODV) == qt));
    if (av) begin
      chk("R2 ticket", int'(iss_tkt), acq_n[as] % MODV);
      fin_after = fin_n[as] + ((dv && ds == as) ? 1 : 0);
      pair_e = 1'b0;
      if (!ak)
        for (int q = fin_after; q < acq_n[as]; q++)
          if (kind_m[as][q % 64]) pair_e = 1'b1;
      // R6 / R8 pairing decision, R5 kind encoding
      chk("R6/R8 paired", int'(iss_paired), int'(pair_e));
    end else begin
      chk("R6 no pair without issue", int'(iss_paired), 0);
    end
    @(posedge clk);
    #1;
    if (dv) fin_n[ds]++;
    if (av) begin
      kind_m[as][acq_n[as] % 64] = ak;
      if (!ak) last_co[as] = acq_n[as];
      acq_n[as]++;
    end
    for (int s = 0; s < NSEG; s++)
      chk("R7 ld_hold", int'(ld_hold[s]), int'(hold_exp(s)));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSEG; s++) begin
      acq_n[s] = 0; fin_n[s] = 0; last_co[s] = -1;
    end
    rst_n = 1'b0;
    iss_vld = 0; iss_seg = '0; iss_ckin = 0;
    fin_vld = 0; fin_seg = '0; fin_ckin = 0;
    ask_seg = '0; ask_tkt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < NSEG; s++) begin
      iss_seg = SW'(s); ask_seg = SW'(s); ask_tkt = '0;
      #1;
      chk("R1 first ticket", int'(iss_tkt), 0);
      chk("R1 grant ticket 0", int'(ask_grant), 1);
    end
    chk("R1 ld_hold", int'(ld_hold), 0);

    // R8: last checkin completes while checkout issues on segment 1
    step(1, 1, 1, 0, 0, 1, 0);
    step(1, 1, 0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 1, 1, 1);
    // R6/R7: checkin, checkout, later checkin, drain
    step(1, 2, 1, 0, 0, 2, 0);
    step(1, 2, 0, 0, 0, 2, 0);
    step(1, 2, 1, 0, 0, 2, 1);
    step(0, 0, 0, 1, 2, 2, 0);  // hold drops, later checkin still pending
    step(0, 0, 0, 1, 2, 2, 1);
    step(0, 0, 0, 1, 2, 2, 2);
    // R4: other segments untouched; check segment 3 still at zero
    step(0, 0, 0, 0, 0, 3, 0);

    // R9 and everything else: long sweep with wrap-around
    for (int n = 0; n < 6000; n++) begin
      int ds, as, qs, qt, outst;
      bit dv, av, ak;
      ds = rnd(NSEG);
      dv = (rnd(3) != 0) && (acq_n[ds] > fin_n[ds]);
      as = rnd(NSEG);
      ak = rnd(2) != 0;
      outst = acq_n[as] - fin_n[as] - ((dv && ds == as) ? 1 : 0);
      av = (rnd(4) != 0) && (outst < MODV - 1);
      qs = rnd(NSEG);
      qt = (rnd(2) != 0) ? (fin_n[qs] % MODV) : rnd(MODV);
      step(av, as, ak, dv, ds, qs, qt);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule